// File: doc/BRIEF.md
# Eight-bit waveform timer/counter

An 8-bit timer/counter with one compare channel and one output pin. A register port sets up the counter. It carries a control byte (clock divider select, counting mode, pin action and a force strobe), a compare byte, the live count, and a flag byte. The flag byte also holds a strobe that restarts the divider. Four counting modes are available: free running, clear-on-compare, fast PWM and phase-correct PWM. The moment the compare value takes effect, and the moment the overflow flag rises, both depend on the mode.

The counter only advances on a divided tick. The divider counts cycles in which `clk_en_i` is high. It can pass every enabled cycle through, pass one in 8, 32, 64, 128, 256 or 1024, or stop entirely. The two flags are raw sticky outputs, meant to be wired to an interrupt controller. Software clears a flag by writing a one to its bit.

Top module: `wave_tmr8`

## Requirements
- R1: After reset every register reads 0. The counter is stopped, and `oc_o`, `ovf_flag_o` and `cmp_flag_o` are 0.
- R2: Register map: address 0 is control, with bits [2:0] the divider select, [4:3] the mode and [6:5] the pin action. Divider select 0 stops the counter. Values 1..7 give one tick per 1, 8, 32, 64, 128, 256 and 1024 enabled cycles respectively.
- R3: Writing 1 to bit 7 of address 3 clears the divider. The next tick then comes exactly one full divide period of enabled cycles later.
- R4: Mode 00 (free running) counts 0..255 and wraps. The overflow flag (address 3 bit 0) is set by the tick that leaves 255.
- R5: Mode 10 (clear-on-compare) goes to 0 on the tick after the count equals the compare value. Each such equal tick sets the compare flag (address 3 bit 1). Overflow is set only when the count leaves 255.
- R6: Mode 01 (phase-correct) counts 0 up to 255, then down to 0, never repeating an end value. The overflow flag is set by each tick taken at count 0.
- R7: A compare write (address 1) takes effect at once in modes 00 and 10. In modes 01 and 11 it is buffered and takes effect on the tick taken at count 255. Reading address 1 returns the last value written.
- R8: In modes 00 and 10 the pin action acts on a compare tick: 01 toggles, 10 drives 0, 11 drives 1. With pin action 00, `oc_o` is 0.
- R9: In mode 11 (fast PWM), pin action 10 drives the pin 0 on a compare tick and 1 on the tick leaving 255; the latter wins if both happen on the same tick. Action 11 is the inverse.
- R10: In mode 01, pin action 10 drives the pin 0 on a compare tick while counting up and 1 while counting down. Action 11 is the inverse.
- R11: Control bit 7 is a write-only strobe, and it reads as 0. In modes 00 and 10 it applies the pin action already in the register at once. It sets no flag and does not clear or move the count. In modes 01 and 11 it has no effect.
- R12: A count write (address 2) overrides a tick in the same cycle. A flag is cleared by writing 1 to its bit, but a set in the same cycle wins.
- R13: While `clk_en_i` is low the divider and the count hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Counting enable fed to the divider |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| oc_o | output | 1 | Compare output pin |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 1 | Sticky compare flag |

## Verification
Software register writes can fall in the same cycle as the counter's own tick. Two cases matter here: a count write against an advancing tick, and a flag-clear write against a flag-setting tick at 255. The bench provokes both by raising `clk_en_i` in the write cycle. It judges the outcome by reading back the count and the flag: the written count must stand, and the flag must stay set. Sweeps over compare values in both PWM modes compare the pin on every tick against an arithmetic model of the up/down sequence.

// File: rtl/wtmr_pkg.sv
package wtmr_pkg;

  typedef enum logic [1:0] {
    WM_NORMAL = 2'b00,
    WM_PHASE  = 2'b01,
    WM_CTC    = 2'b10,
    WM_FAST   = 2'b11
  } wmode_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CMP  = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  // log2 of the divide ratio for each select code
  function automatic int unsigned presc_bits(input logic [2:0] sel);
    case (sel)
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction

  function automatic logic is_pwm(input wmode_e m);
    return (m == WM_PHASE) || (m == WM_FAST);
  endfunction

endpackage

// File: rtl/wtmr_presc.sv
module wtmr_presc #(
  parameter int unsigned PW = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] sel_i,
  input  logic       clr_i,
  output logic       tick_o
);
  import wtmr_pkg::*;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] mask;

  always_comb begin
    mask   = PW'((1 << presc_bits(sel_i)) - 1);
    tick_o = en_i && (sel_i != 3'd0) && !clr_i && ((cnt_q & mask) == mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (en_i && sel_i != 3'd0)    cnt_q <= cnt_q + 1'b1;
  end

  AST_PRE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o); // R13
  AST_PRE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !(tick_o && sel_i >= 3'd2)); // R3

endmodule

// File: rtl/wtmr_cnt.sv
module wtmr_cnt #(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  wtmr_pkg::wmode_e  mode_i,
  input  logic [W-1:0]      cmp_i,
  input  logic              ld_i,
  input  logic [W-1:0]      ld_val_i,
  output logic [W-1:0]      cnt_o,
  output logic              down_o,
  output logic              ev_match_o,
  output logic              ev_max_o,
  output logic              ev_zero_o
);
  import wtmr_pkg::*;

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         down_q;
  logic         go;

  assign go         = tick_i && !ld_i;
  assign ev_match_o = go && (cnt_q == cmp_i);
  assign ev_max_o   = go && (cnt_q == MAXV);
  assign ev_zero_o  = go && (cnt_q == '0);
  assign cnt_o      = cnt_q;
  assign down_o     = down_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      if (mode_i != WM_PHASE) down_q <= 1'b0;
      if (ld_i) begin
        cnt_q <= ld_val_i;
      end else if (tick_i) begin
        unique case (mode_i)
          WM_PHASE: begin
            if (!down_q) begin
              if (cnt_q == MAXV) begin
                cnt_q  <= MAXV - 1'b1;
                down_q <= 1'b1;
              end else cnt_q <= cnt_q + 1'b1;
            end else begin
              if (cnt_q == '0) begin
                cnt_q  <= W'(1);
                down_q <= 1'b0;
              end else cnt_q <= cnt_q - 1'b1;
            end
          end
          WM_CTC:  cnt_q <= (cnt_q == cmp_i) ? '0 : cnt_q + 1'b1;
          default: cnt_q <= cnt_q + 1'b1;
        endcase
      end
    end
  end

  AST_CTC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == WM_CTC && ev_match_o) |=> cnt_o == '0); // R5
  AST_PC_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == WM_PHASE && ev_max_o && !down_o) |=> (down_o && cnt_o == MAXV - 1'b1)); // R6
  AST_PC_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == WM_PHASE && ev_zero_o && down_o) |=> (!down_o && cnt_o == W'(1))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ld_i) |=> $stable(cnt_o)); // R13

endmodule

// File: rtl/wtmr_ocu.sv
module wtmr_ocu (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wtmr_pkg::wmode_e mode_i,
  input  logic [1:0]       act_i,
  input  logic             force_i,
  input  logic             match_i,
  input  logic             max_i,
  input  logic             down_i,
  output logic             oc_o
);
  import wtmr_pkg::*;

  logic oc_q;
  logic connected;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oc_q <= 1'b0;
    end else begin
      unique case (mode_i)
        WM_FAST: begin
          if (act_i[1]) begin
            if (max_i)        oc_q <= !act_i[0];
            else if (match_i) oc_q <= act_i[0];
          end
        end
        WM_PHASE: begin
          if (act_i[1] && match_i) oc_q <= down_i ^ act_i[0];
        end
        default: begin
          if (match_i || force_i) begin
            unique case (act_i)
              2'b01:   oc_q <= !oc_q;
              2'b10:   oc_q <= 1'b0;
              2'b11:   oc_q <= 1'b1;
              default: oc_q <= oc_q;
            endcase
          end
        end
      endcase
    end
  end

  // action 01 is not defined in the PWM modes: pin stays disconnected
  assign connected = (act_i != 2'b00) && !(is_pwm(mode_i) && act_i == 2'b01);
  assign oc_o      = connected && oc_q;

  AST_FAST_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == WM_FAST && act_i == 2'b10 && max_i) |=> oc_q); // R9
  AST_PWM_NO_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pwm(mode_i) && force_i && !match_i && !max_i) |=> $stable(oc_q)); // R11
  AST_SET_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_pwm(mode_i) && act_i == 2'b11 && match_i) |=> oc_q); // R8

endmodule

// File: rtl/wave_tmr8.sv
module wave_tmr8 #(
  parameter int unsigned PRE_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clk_en_i,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       oc_o,
  output logic       ovf_flag_o,
  output logic       cmp_flag_o
);
  import wtmr_pkg::*;

  localparam int unsigned DW = 8;

  logic [2:0]    sel_q;
  wmode_e        mode_q;
  logic [1:0]    act_q;
  logic [DW-1:0] cmp_buf_q, cmp_act_q;
  logic          ovf_q, cmpf_q;

  logic wr_ctrl, wr_cmp, wr_cnt, wr_flag;
  logic force_stb, presc_clr, tick;
  logic [DW-1:0] cnt;
  logic down, ev_match, ev_max, ev_zero, ovf_set;

  assign wr_ctrl   = we_i && addr_i == A_CTRL;
  assign wr_cmp    = we_i && addr_i == A_CMP;
  assign wr_cnt    = we_i && addr_i == A_CNT;
  assign wr_flag   = we_i && addr_i == A_FLAG;
  assign force_stb = wr_ctrl && wdata_i[7];
  assign presc_clr = wr_flag && wdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      mode_q <= WM_NORMAL;
      act_q  <= '0;
    end else if (wr_ctrl) begin
      sel_q  <= wdata_i[2:0];
      mode_q <= wmode_e'(wdata_i[4:3]);
      act_q  <= wdata_i[6:5];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_buf_q <= '0;
      cmp_act_q <= '0;
    end else begin
      if (wr_cmp) cmp_buf_q <= wdata_i;
      if (wr_cmp && !is_pwm(mode_q))     cmp_act_q <= wdata_i;
      else if (is_pwm(mode_q) && ev_max) cmp_act_q <= cmp_buf_q;
    end
  end

  assign ovf_set = (mode_q == WM_PHASE) ? ev_zero : ev_max;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q  <= 1'b0;
      cmpf_q <= 1'b0;
    end else begin
      ovf_q  <= ovf_set  || (ovf_q  && !(wr_flag && wdata_i[0]));
      cmpf_q <= ev_match || (cmpf_q && !(wr_flag && wdata_i[1]));
    end
  end

  wtmr_presc #(.PW(PRE_W)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (clk_en_i),
    .sel_i  (sel_q),
    .clr_i  (presc_clr),
    .tick_o (tick)
  );

  wtmr_cnt #(.W(DW)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .mode_i     (mode_q),
    .cmp_i      (cmp_act_q),
    .ld_i       (wr_cnt),
    .ld_val_i   (wdata_i),
    .cnt_o      (cnt),
    .down_o     (down),
    .ev_match_o (ev_match),
    .ev_max_o   (ev_max),
    .ev_zero_o  (ev_zero)
  );

  wtmr_ocu i_ocu (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_q),
    .act_i   (act_q),
    .force_i (force_stb),
    .match_i (ev_match),
    .max_i   (ev_max),
    .down_i  (down),
    .oc_o    (oc_o)
  );

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {1'b0, act_q, mode_q, sel_q};
      A_CMP:   rdata_o = cmp_buf_q;
      A_CNT:   rdata_o = cnt;
      default: rdata_o = {6'b0, cmpf_q, ovf_q};
    endcase
  end

  assign ovf_flag_o = ovf_q;
  assign cmp_flag_o = cmpf_q;

  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set |=> ovf_flag_o); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !(wr_flag && wdata_i[0])) |=> ovf_flag_o); // R12
  AST_PWM_CMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pwm(mode_q) && !ev_max) |=> $stable(cmp_act_q)); // R7
  AST_FORCE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_stb && !ev_match && !cmp_flag_o && !clk_en_i) |=> !cmp_flag_o); // R11

endmodule

// File: tb/test_wave_tmr8.sv
module test_wave_tmr8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clk_en_i = 1'b0;
  logic       we_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       oc_o, ovf_flag_o, cmp_flag_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  wave_tmr8 i_wave_tmr8 (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_en_i(clk_en_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .oc_o(oc_o),
    .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d, input bit en = 0);
    addr_i = 2'(a); wdata_i = 8'(d); we_i = 1'b1; clk_en_i = en;
    @(negedge clk_i);
    we_i = 1'b0; clk_en_i = 1'b0;
  endtask

  task automatic tick(input int n);
    clk_en_i = 1'b1;
    repeat (n) @(negedge clk_i);
    clk_en_i = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr_i = 2'(a);
    #1;
    v = int'(rdata_o);
  endtask

  task automatic set_ctrl(input int sel, input int mode, input int act);
    wr(0, (act << 5) | (mode << 3) | sel);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, c, d, mo, mc, oc, errs;
    int divs[7] = '{1, 8, 32, 64, 128, 256, 1024};
    int pvals[5] = '{0, 1, 128, 254, 255};

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(a, v); chk("R1 register reset", v, 0); end
    chk("R1 oc reset", oc_o, 0);
    chk("R1 flags reset", {ovf_flag_o, cmp_flag_o}, 0);
    tick(20); rd(2, v); chk("R1 stopped after reset", v, 0);

    // R2 / R3 divider ratios after a divider restart
    for (int s = 1; s <= 7; s++) begin
      set_ctrl(s, 0, 0); wr(2, 0); wr(3, 8'h80);
      tick(3 * divs[s-1] - 1); rd(2, v); chk("R2 divider ratio early", v, 2);
      tick(1); rd(2, v); chk("R3 divider exact edge", v, 3);
    end
    set_ctrl(2, 0, 0); wr(2, 0); wr(3, 8'h80);
    tick(5); wr(3, 8'h80); tick(7); rd(2, v); chk("R3 restart mid period", v, 0);
    tick(1); rd(2, v); chk("R3 restart mid period tick", v, 1);
    set_ctrl(0, 0, 0); wr(2, 9); tick(50); rd(2, v); chk("R2 stop select", v, 9);

    // R13 enable low freezes
    set_ctrl(3, 0, 0); wr(2, 0); wr(3, 8'h80);
    tick(20); repeat (100) @(negedge clk_i); tick(11); rd(2, v); chk("R13 divider hold", v, 0);
    tick(1); rd(2, v); chk("R13 divider resume", v, 1);

    // R4 free running sweep
    set_ctrl(1, 0, 0); wr(2, 0); wr(3, 3);
    errs = 0;
    for (int i = 1; i <= 255; i++) begin tick(1); rd(2, v); if (v != i) errs++; end
    chk("R4 count sweep", errs, 0);
    chk("R4 no overflow before wrap", ovf_flag_o, 0);
    tick(1); rd(2, v); chk("R4 wrap to zero", v, 0);
    chk("R4 overflow on leaving 255", ovf_flag_o, 1);

    // R5 clear-on-compare sweep
    foreach (pvals[p]) begin
      set_ctrl(1, 0, 0); wr(1, pvals[p]); set_ctrl(1, 2, 0); wr(2, 0); wr(3, 3);
      c = 0; mo = 0; mc = 0; errs = 0;
      for (int k = 0; k < 520; k++) begin
        if (c == pvals[p]) mc = 1;
        if (c == 255) mo = 1;
        c = (c == pvals[p]) ? 0 : (c + 1) & 255;
        tick(1); rd(2, v); if (v != c) errs++;
      end
      chk("R5 ctc count sequence", errs, 0);
      chk("R5 ctc compare flag", cmp_flag_o, mc);
      chk("R5 ctc overflow flag", ovf_flag_o, mo);
    end

    // R6 phase-correct sequence
    set_ctrl(1, 0, 0); set_ctrl(1, 1, 0); wr(2, 0); wr(3, 3);
    c = 0; d = 0; mo = 0; errs = 0;
    for (int k = 0; k < 1100; k++) begin
      if (k == 100) begin wr(3, 1); mo = 0; end
      if (k == 400) chk("R6 no overflow away from bottom", ovf_flag_o, mo);
      if (c == 0) mo = 1;
      if (!d) begin if (c == 255) begin c = 254; d = 1; end else c++; end
      else    begin if (c == 0)   begin c = 1;   d = 0; end else c--; end
      tick(1); rd(2, v); if (v != c) errs++;
    end
    chk("R6 up/down sequence", errs, 0);
    chk("R6 overflow at bottom", ovf_flag_o, mo);

    // R7 compare update points
    set_ctrl(1, 0, 0); wr(2, 0); wr(1, 20); wr(3, 3); tick(21);
    chk("R7 immediate compare", cmp_flag_o, 1);
    wr(1, 50); set_ctrl(1, 3, 0); wr(2, 0); wr(1, 200); wr(3, 3);
    rd(1, v); chk("R7 compare readback", v, 200);
    tick(60); chk("R7 old value still active", cmp_flag_o, 1);
    wr(3, 3); tick(150); chk("R7 new value not yet active", cmp_flag_o, 0);
    tick(46); rd(2, v); chk("R7 wrap", v, 0);
    wr(3, 3); tick(100); chk("R7 old value retired", cmp_flag_o, 0);
    tick(111); chk("R7 new value active after wrap", cmp_flag_o, 1);

    // R8 non-PWM pin actions
    set_ctrl(1, 0, 0); wr(1, 10);
    set_ctrl(1, 0, 3); wr(2, 0); tick(11); chk("R8 set on match", oc_o, 1);
    set_ctrl(1, 0, 2); wr(2, 0); tick(10); chk("R8 before match", oc_o, 1);
    tick(1); chk("R8 clear on match", oc_o, 0);
    set_ctrl(1, 0, 1); wr(2, 0); tick(11); chk("R8 toggle high", oc_o, 1);
    wr(2, 0); tick(11); chk("R8 toggle low", oc_o, 0);
    wr(2, 0); tick(11); set_ctrl(1, 0, 0); chk("R8 disconnected", oc_o, 0);
    set_ctrl(1, 2, 1); wr(2, 0); oc = 1; errs = 0;
    for (int k = 0; k < 4; k++) begin tick(11); oc = 1 - oc; if (oc_o != oc) errs++; end
    chk("R8 ctc toggle period", errs, 0);

    // R9 fast PWM pin sweep
    foreach (pvals[p]) for (int a = 2; a <= 3; a++) begin
      set_ctrl(1, 0, 0); wr(1, pvals[p]); set_ctrl(1, 3, a); wr(2, 0);
      c = 0; oc = 0; errs = 0;
      for (int k = 0; k < 512; k++) begin
        if (c == 255) oc = 1 - (a & 1);
        else if (c == pvals[p]) oc = a & 1;
        c = (c + 1) & 255;
        tick(1); if (k >= 256 && oc_o != oc) errs++;
      end
      chk("R9 fast PWM pin", errs, 0);
    end

    // R10 phase-correct pin sweep
    foreach (pvals[p]) for (int a = 2; a <= 3; a++) begin
      set_ctrl(1, 0, 0); wr(1, pvals[p]); set_ctrl(1, 1, a); wr(2, 0);
      c = 0; d = 0; oc = 0; errs = 0;
      for (int k = 0; k < 1020; k++) begin
        if (c == pvals[p]) oc = d ^ (a & 1);
        if (!d) begin if (c == 255) begin c = 254; d = 1; end else c++; end
        else    begin if (c == 0)   begin c = 1;   d = 0; end else c--; end
        tick(1); if (k >= 510 && oc_o != oc) errs++;
      end
      chk("R10 phase-correct pin", errs, 0);
    end

    // R11 force strobe
    set_ctrl(1, 0, 1); wr(2, 5); wr(1, 200); wr(3, 3);
    oc = oc_o; wr(0, 8'hA1);
    chk("R11 force toggles", oc_o, 1 - oc);
    chk("R11 force sets no flag", {ovf_flag_o, cmp_flag_o}, 0);
    rd(0, v); chk("R11 strobe reads zero", v, 8'h21);
    set_ctrl(1, 2, 1); wr(1, 5); wr(2, 5); wr(3, 3);
    oc = oc_o; wr(0, 8'hB1); rd(2, v);
    chk("R11 force keeps ctc count", v, 5);
    chk("R11 force toggles in ctc", oc_o, 1 - oc);
    chk("R11 no compare flag in ctc", cmp_flag_o, 0);
    tick(1); rd(2, v); chk("R11 real match still clears", v, 0);
    set_ctrl(1, 3, 2); oc = oc_o; wr(0, 8'hD9);
    chk("R11 force ignored in fast PWM", oc_o, oc);

    // R12 same-cycle collisions
    set_ctrl(1, 0, 0); wr(2, 10); wr(2, 77, 1);
    rd(2, v); chk("R12 count write beats tick", v, 77);
    wr(2, 254); wr(3, 3); tick(1);
    chk("R12 no overflow yet", ovf_flag_o, 0);
    wr(3, 3, 1);
    chk("R12 set beats clear", ovf_flag_o, 1);
    rd(2, v); chk("R12 tick with flag write", v, 0);
    wr(3, 1); chk("R12 clear by write one", ovf_flag_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule